// File: doc/BRIEF.md
# Iteration Bound Engine (Longest Path Matrices)

This block computes the iteration bound of a data-flow graph. The host first writes the first-order delay-to-delay matrix through a load port. Entry (row, col) is the longest computation time of any path that leaves delay element `row` and reaches delay element `col` without passing through another delay. An entry can also be marked as having no such path.

After a start pulse that carries the delay count d, the engine builds the higher-order matrices one at a time. Each new matrix is the max-plus product of the first-order matrix with the current one. For each order m it reads every diagonal entry, forms the ratio entry/m, and keeps the largest. Ratios are compared by cross-multiplication, so the block contains no divider. The result comes out as a numerator/denominator pair with a one-cycle done pulse. If the graph contains no loop at all, a no-loop flag is raised with done.

Only the first-order matrix and the current matrix are kept, and a third bank receives the product that is being built. The process is fully sequential: one diagonal entry per cycle in a scan, and one product term per cycle in a multiply.

Top module: `lpm_bound_engine`

## Requirements
- R1: After reset, busy, done and no_loop are low, and bound_num and bound_den are zero.
- R2: A cycle with ld_en high while the engine is idle writes entry (ld_row, ld_col) of the first-order matrix. ld_none=1 marks the entry as "no path"; otherwise the entry holds the unsigned value ld_val. Writes made while busy is high are ignored.
- R3: A start pulse seen while idle latches num_dly as the delay count d, and busy goes high on the next cycle. A num_dly above N is treated as N. A start pulse seen while busy is ignored.
- R4: For m from 1 to d−1, entry (i,j) of matrix m+1 is the maximum over k of first(i,k) + matrix_m(k,j). Only those k are used for which both terms hold a path; if no k qualifies, the entry is "no path".
- R5: The result is the largest value of matrix_m(i,i)/m over m = 1..d and i = 0..d−1, skipping "no path" entries. It is reported with bound_num = matrix_m(i,i) and bound_den = m.
- R6: A candidate replaces the running best only when its ratio is strictly larger. On a tie, the earlier candidate is kept: the one with the lower order, and within one order the lower index.
- R7: If no diagonal entry of any order holds a path, done is raised together with no_loop=1, and bound_num = bound_den = 0.
- R8: A start pulse with num_dly = 0 produces done and no_loop on the very next cycle, and busy never goes high.
- R9: For d ≥ 1, done is a one-cycle pulse on the clock edge d·d + (d−1)·d³ cycles after the edge that accepted start. busy falls on that same edge. The results and no_loop hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write strobe for the first-order matrix |
| ld_row | input | $clog2(N) | Source delay index of the entry |
| ld_col | input | $clog2(N) | Destination delay index of the entry |
| ld_none | input | 1 | Marks the entry as "no path" |
| ld_val | input | W | Path time of the entry |
| start | input | 1 | Begin a computation |
| num_dly | input | $clog2(N+1) | Delay count d, sampled with start |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| no_loop | output | 1 | The graph has no loop |
| bound_num | output | W+$clog2(N) | Numerator of the iteration bound |
| bound_den | output | $clog2(N+1) | Denominator (order m) of the iteration bound |

## Verification
Every internal fault in this block is seen only at the end of a run. A wrong product entry, a wrong bank select, or a lost sentinel changes bound_num, bound_den or no_loop when done fires. A wrong loop bound on i, j, k or m moves the done pulse away from the cycle that the d·d + (d−1)·d³ formula predicts. The bench therefore tracks busy and done against the expected count on every clock, and compares the final pair with a behavioural max-plus model. That model includes the tie rule, so a swapped comparison shows up as a different numerator/denominator pair even when the ratio is the same.

// File: rtl/lpm_bound_engine.sv
module lpm_bound_engine #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [$clog2(N)-1:0]     ld_row,
  input  logic [$clog2(N)-1:0]     ld_col,
  input  logic                     ld_none,
  input  logic [W-1:0]             ld_val,
  input  logic                     start,
  input  logic [$clog2(N+1)-1:0]   num_dly,
  output logic                     busy,
  output logic                     done,
  output logic                     no_loop,
  output logic [W+$clog2(N)-1:0]   bound_num,
  output logic [$clog2(N+1)-1:0]   bound_den
);
  localparam int IW = $clog2(N);
  localparam int MW = $clog2(N+1);
  localparam int VW = W + $clog2(N);
  localparam int PW = VW + MW;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_MUL} st_t;

  st_t            st;
  logic           ok_q  [3][N][N];
  logic [VW-1:0]  val_q [3][N][N];
  logic [MW-1:0]  dd, m;
  logic [IW-1:0]  i, j, k;
  logic [1:0]     cur;
  logic           have;
  logic           acc_ok;
  logic [VW-1:0]  acc_v;

  logic [1:0]     nxt;
  logic [MW-1:0]  ddm1;
  logic [IW-1:0]  lim;
  logic           e_ok, take;
  logic [VW-1:0]  e_v;
  logic [PW-1:0]  lhs, rhs;
  logic           c_ok, base_ok, n_ok;
  logic [VW-1:0]  sum, base_v, n_v;

  assign busy = (st != S_IDLE);
  assign nxt  = (cur == 2'd1) ? 2'd2 : 2'd1;
  assign ddm1 = dd - 1'b1;
  assign lim  = ddm1[IW-1:0];

  // diagonal scan: compare e_v/m against bound_num/bound_den without division
  assign e_ok = ok_q[cur][i][i];
  assign e_v  = val_q[cur][i][i];
  assign lhs  = PW'(e_v) * PW'(bound_den);
  assign rhs  = PW'(bound_num) * PW'(m);
  assign take = e_ok && (!have || lhs > rhs);

  // max-plus product term
  assign c_ok    = ok_q[0][i][k] && ok_q[cur][k][j];
  assign sum     = val_q[0][i][k] + val_q[cur][k][j];
  assign base_ok = (k == '0) ? 1'b0 : acc_ok;
  assign base_v  = acc_v;
  assign n_ok    = base_ok || c_ok;
  assign n_v     = (c_ok && (!base_ok || sum > base_v)) ? sum : base_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dd        <= '0;
      m         <= '0;
      i         <= '0;
      j         <= '0;
      k         <= '0;
      cur       <= '0;
      have      <= 1'b0;
      acc_ok    <= 1'b0;
      acc_v     <= '0;
      done      <= 1'b0;
      no_loop   <= 1'b0;
      bound_num <= '0;
      bound_den <= '0;
      for (int b = 0; b < 3; b++)
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++) begin
            ok_q[b][r][c]  <= 1'b0;
            val_q[b][r][c] <= '0;
          end
    end else begin
      done <= 1'b0;
      if (ld_en && st == S_IDLE) begin
        ok_q[0][ld_row][ld_col]  <= !ld_none;
        val_q[0][ld_row][ld_col] <= VW'(ld_val);
      end
      case (st)
        S_IDLE: if (start) begin
          bound_num <= '0;
          bound_den <= '0;
          have      <= 1'b0;
          no_loop   <= 1'b0;
          if (num_dly == '0) begin
            done    <= 1'b1;
            no_loop <= 1'b1;
          end else begin
            dd  <= (num_dly > MW'(N)) ? MW'(N) : num_dly;
            m   <= MW'(1);
            i   <= '0;
            cur <= 2'd0;
            st  <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (take) begin
            bound_num <= e_v;
            bound_den <= m;
            have      <= 1'b1;
          end
          if (i == lim) begin
            i <= '0;
            if (m == dd) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              no_loop <= !(have || take);
            end else begin
              st <= S_MUL;
              j  <= '0;
              k  <= '0;
            end
          end else begin
            i <= i + 1'b1;
          end
        end
        S_MUL: begin
          acc_ok <= n_ok;
          acc_v  <= n_v;
          if (k == lim) begin
            ok_q[nxt][i][j]  <= n_ok;
            val_q[nxt][i][j] <= n_v;
            k <= '0;
            if (j == lim) begin
              j <= '0;
              if (i == lim) begin
                i   <= '0;
                cur <= nxt;
                m   <= m + 1'b1;
                st  <= S_SCAN;
              end else begin
                i <= i + 1'b1;
              end
            end else begin
              j <= j + 1'b1;
            end
          end else begin
            k <= k + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_count_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dd));

  p_order_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (m >= MW'(1) && m <= dd));

  p_den_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_loop) |-> (bound_den != '0 && bound_den <= dd));

  p_noloop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_loop) |-> (bound_num == '0 && bound_den == '0));
endmodule

// File: tb/test_lpm_bound_engine.sv
`timescale 1ns/1ps
module test_lpm_bound_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_row = '0, ld_col = '0;
  logic        ld_none = 1'b0;
  logic [7:0]  ld_val = '0;
  logic        start = 1'b0;
  logic [3:0]  num_dly = '0;
  logic        busy, done, no_loop;
  logic [10:0] bound_num;
  logic [3:0]  bound_den;

  int tests = 0, fails = 0;
  int l1 [8][8];
  int exp_num, exp_den, exp_nl;

  always #5 clk = ~clk;

  lpm_bound_engine #(.N(8), .W(8)) i_lpm_bound_engine (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col),
    .ld_none(ld_none), .ld_val(ld_val), .start(start), .num_dly(num_dly),
    .busy(busy), .done(done), .no_loop(no_loop),
    .bound_num(bound_num), .bound_den(bound_den));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_l1();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) l1[r][c] = -1;
  endtask

  task automatic load_l1();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_row = 3'(r); ld_col = 3'(c);
        ld_none = (l1[r][c] < 0); ld_val = 8'(l1[r][c] < 0 ? 0 : l1[r][c]);
      end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic model(input int d);
    int lc [8][8];
    int ln [8][8];
    int have;
    have = 0; exp_num = 0; exp_den = 0;
    for (int m = 1; m <= d; m++) begin
      if (m == 1) begin
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) lc[r][c] = l1[r][c];
      end else begin
        for (int r = 0; r < d; r++)
          for (int c = 0; c < d; c++) begin
            ln[r][c] = -1;
            for (int q = 0; q < d; q++)
              if (l1[r][q] >= 0 && lc[q][c] >= 0 && l1[r][q] + lc[q][c] > ln[r][c])
                ln[r][c] = l1[r][q] + lc[q][c];
          end
        for (int r = 0; r < d; r++) for (int c = 0; c < d; c++) lc[r][c] = ln[r][c];
      end
      for (int r = 0; r < d; r++)
        if (lc[r][r] >= 0 && (have == 0 || lc[r][r] * exp_den > exp_num * m)) begin
          have = 1; exp_num = lc[r][r]; exp_den = m;
        end
    end
    exp_nl = (have == 0);
  endtask

  task automatic run(input int nd, input bit poke, input string tag);
    int d, t;
    d = (nd > 8) ? 8 : nd;
    model(d);
    t = d * d + (d - 1) * d * d * d;
    @(negedge clk);
    start = 1'b1; num_dly = 4'(nd);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= t; c++) begin
      if (c > 0) @(negedge clk);
      check(busy == (c < t) && done == (c == t), {tag, " R9 busy/done timing"},
            {busy, done}, {(c < t), (c == t)});
      if (poke && c == 5) begin
        start = 1'b1; ld_en = 1'b1; ld_row = 3'd0; ld_col = 3'd0; ld_none = 1'b0; ld_val = 8'd255;
      end
      if (poke && c == 6) begin
        start = 1'b0; ld_en = 1'b0;
      end
    end
    @(negedge clk);
    check(!done && !busy, {tag, " R9 done is one pulse"}, {busy, done}, 0);
    check(no_loop == exp_nl, {tag, " R7 no_loop"}, no_loop, exp_nl);
    check(bound_num == exp_num, {tag, " R5 numerator"}, bound_num, exp_num);
    check(bound_den == exp_den, {tag, " R5 denominator"}, bound_den, exp_den);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !no_loop, "R1 flags after reset", {busy, done, no_loop}, 0);
    check(bound_num == 0 && bound_den == 0, "R1 result after reset", bound_num, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5: four-delay graph, bound 2 reached first as 4/2
    clear_l1();
    l1[0][1] = 0; l1[1][0] = 4; l1[1][2] = 0; l1[2][0] = 5; l1[2][3] = 0; l1[3][0] = 5;
    load_l1();
    run(4, 1'b0, "four-delay");
    check(bound_num == 2 * bound_den, "R5 ratio equals 2", bound_num, 2 * bound_den);

    // R4: two-delay graph, bound 8 as 16/2
    clear_l1();
    l1[0][1] = 4; l1[1][0] = 12;
    load_l1();
    run(2, 1'b0, "two-delay");
    check(bound_num == 16 && bound_den == 2, "R4 product 16/2", bound_num, 16);

    // R6: 3/1 and 6/2 tie, lower order kept
    clear_l1();
    l1[0][0] = 3; l1[1][1] = 3;
    load_l1();
    run(2, 1'b0, "tie");
    check(bound_num == 3 && bound_den == 1, "R6 tie keeps first", bound_num, 3);

    // R7: acyclic graph
    clear_l1();
    l1[0][1] = 2; l1[0][2] = 3; l1[1][2] = 4;
    load_l1();
    run(3, 1'b0, "acyclic");
    check(no_loop == 1'b1, "R7 no loop flagged", no_loop, 1);

    // R5: single delay with self loop
    clear_l1();
    l1[0][0] = 7;
    load_l1();
    run(1, 1'b0, "single");

    // R8: zero delays
    run(0, 1'b0, "zero-delay R8");

    // R2 R3: full eight-delay graph, start and load poked while busy
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        l1[r][c] = ((r * 3 + c * 5) % 7 == 0) ? -1 : (r * 37 + c * 91 + 13) % 256;
    load_l1();
    run(8, 1'b1, "full R2 R3 ignored while busy");

    // R3: count above N clamps to N
    run(12, 1'b0, "clamp R3");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule